// File: doc/BRIEF.md
# Audio Serial Output Clock Generator

This block turns a master audio clock into the two clocks an I2S-style output port needs: a serial bit clock and a left/right frame clock. The ratio from the master clock to the bit clock is an integer divider. The number of bit clocks in one frame comes either from a free 12-bit count or from a 2-bit payload code. Each clock has its own polarity inversion. Alongside the clocks the block emits single-cycle strobes in the master clock domain, which a downstream serializer uses to shift data and to track channel boundaries.

A small control section holds the divider enable. Start, pause and stop commands drive it, and a continuous/gated idle policy decides what a pause does. The divider and frame settings are captured only while the divider is stopped. Changing them therefore never disturbs a clock that is already running.

Top module: `audio_clk_gen`

## Requirements
- R1: Reset is synchronous and active high. After reset the divider is stopped, the strobes are low, bclkOut equals bclkInv and fclkOut equals fclkInv.
- R2: A start command enables the divider from the next cycle. While the divider runs, the uninverted bit clock starts low and each of its half-periods lasts ratioM1+1 master cycles.
- R3: When lenFromCount is 1, a frame lasts frameM1+1 bit clocks, and this count must be at least 2. When lenFromCount is 0, payloadCode sets the frame length: code 0 gives 32, code 2 gives 48 and code 3 gives 64. The unused code 1 falls back to 32.
- R4: bclkInv inverts the bit clock and fclkInv inverts the frame clock, independently. All four combinations apply both while running and while stopped.
- R5: Within each frame of L bit clocks, the uninverted frame clock is low for the first floor(L/2) bits and high for the remaining bits. The first frame after a start begins low.
- R6: A stop command always disables the divider. A pause command disables it only when contMode is 0; with contMode 1 the clocks keep running. If commands arrive together, stop wins over a gated pause, and a gated pause wins over start.
- R7: While the divider is disabled, both uninverted clocks are low and all strobes are low. Every start restarts the bit, half-period and frame counts from zero.
- R8: bitStb is high for exactly the master cycle that precedes each falling edge of the uninverted bit clock, which is each bit boundary after the first.
- R9: frameStb is high in the bitStb cycle that ends the last bit of a frame. halfStb is high in the bitStb cycle that ends bit floor(L/2)-1, where the frame clock rises next.
- R10: ratioM1, frameM1, payloadCode and lenFromCount are captured only while the divider is stopped. Changes made while it runs take effect only after a stop and a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous reset, active high |
| startCmd | input | 1 | Start/resume pulse |
| pauseCmd | input | 1 | Pause pulse, subject to idle policy |
| stopCmd | input | 1 | Stop/suspend pulse |
| contMode | input | 1 | 1 = clocks keep running through a pause |
| ratioM1 | input | 6 | Master-to-bit-clock half-period ratio minus 1 |
| frameM1 | input | 12 | Bit clocks per frame minus 1 |
| payloadCode | input | 2 | Frame length code (0:32, 2:48, 3:64, 1:32) |
| lenFromCount | input | 1 | 1 = frame length from frameM1, 0 = from payloadCode |
| bclkInv | input | 1 | Invert bit clock output |
| fclkInv | input | 1 | Invert frame clock output |
| bclkOut | output | 1 | Bit clock |
| fclkOut | output | 1 | Frame (left/right) clock |
| bitStb | output | 1 | Cycle before a bit boundary |
| frameStb | output | 1 | Cycle before a frame boundary |
| halfStb | output | 1 | Cycle before the left-to-right channel boundary |

## Verification
The embedded assertions check, on every cycle, that the counters clear while the divider is stopped and that the half-period count never passes its latched limit. They also check that the configuration stays frozen while running, that a bit strobe is always followed by a low bit clock, that the frame clock is low right after a frame strobe, and that the control priorities hold. Exact waveform periods, frame lengths for each payload code, odd frame counts, the effect of each polarity combination, and the continuous versus gated pause outcome can be shown only by the bench scenarios. In those scenarios a behavioural model, built on elapsed time since start, is compared against the outputs on every cycle.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;
  // control-to-datapath strobes
  typedef struct packed {
    logic run;   // divider enabled, counters advance
    logic load;  // settings may be captured
  } clkCtl_t;

  localparam int LEN_CODE0 = 32;
  localparam int LEN_CODE2 = 48;
  localparam int LEN_CODE3 = 64;

  // frame length minus one from the payload code; unused code falls back to 32
  function automatic int payloadLenM1(input logic [1:0] code);
    case (code)
      2'd2:    payloadLenM1 = LEN_CODE2 - 1;
      2'd3:    payloadLenM1 = LEN_CODE3 - 1;
      default: payloadLenM1 = LEN_CODE0 - 1;
    endcase
  endfunction
endpackage

// File: rtl/audio_clk_ctrl.sv
module audio_clk_ctrl
  import audio_clk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    startCmd,
  input  logic    pauseCmd,
  input  logic    stopCmd,
  input  logic    contMode,
  output clkCtl_t ctl
);
  logic running;
  logic runNext;

  // stop beats a gated pause, which beats start
  always_comb begin
    runNext = running;
    if (stopCmd)                    runNext = 1'b0;
    else if (pauseCmd && !contMode) runNext = 1'b0;
    else if (startCmd)              runNext = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) running <= 1'b0;
    else     running <= runNext;
  end

  assign ctl.run  = running;
  assign ctl.load = !running;

  // R6: stop always disables
  a_r6_stop_wins: assert property (@(posedge clk) disable iff (rst)
    stopCmd |=> !ctl.run);
  // R6: gated pause disables
  a_r6_gated_pause: assert property (@(posedge clk) disable iff (rst)
    (pauseCmd && !contMode) |=> !ctl.run);
  // R6: continuous pause keeps clocks
  a_r6_cont_pause: assert property (@(posedge clk) disable iff (rst)
    (pauseCmd && contMode && !stopCmd && ctl.run) |=> ctl.run);
endmodule

// File: rtl/audio_clk_dp.sv
module audio_clk_dp
  import audio_clk_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  clkCtl_t          ctl,
  input  logic [DIV_W-1:0] ratioM1,
  input  logic [CNT_W-1:0] frameM1,
  input  logic [1:0]       payloadCode,
  input  logic             lenFromCount,
  input  logic             bclkInv,
  input  logic             fclkInv,
  output logic             bclkOut,
  output logic             fclkOut,
  output logic             bitStb,
  output logic             frameStb,
  output logic             halfStb
);
  localparam logic [CNT_W-1:0] RST_LEN_M1 = CNT_W'(LEN_CODE0 - 1);
  localparam logic [CNT_W-1:0] RST_HALF   = CNT_W'(LEN_CODE0 / 2);

  logic [DIV_W-1:0] ratioLat;
  logic [CNT_W-1:0] lenLat;
  logic [CNT_W-1:0] halfLat;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             bclkRaw;
  logic             fclkRaw;
  logic [CNT_W-1:0] lenSel;
  logic [CNT_W-1:0] halfSel;
  logic             bitEdge;

  // frame length minus one, and floor(length/2)
  always_comb begin
    if (lenFromCount) lenSel = frameM1;
    else              lenSel = CNT_W'(payloadLenM1(payloadCode));
    halfSel = (lenSel >> 1) + CNT_W'(lenSel[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ratioLat <= '0;
      lenLat   <= RST_LEN_M1;
      halfLat  <= RST_HALF;
      divCnt   <= '0;
      bitCnt   <= '0;
      bclkRaw  <= 1'b0;
    end else begin
      if (ctl.load) begin
        ratioLat <= ratioM1;
        lenLat   <= lenSel;
        halfLat  <= halfSel;
      end
      if (!ctl.run) begin
        divCnt  <= '0;
        bitCnt  <= '0;
        bclkRaw <= 1'b0;
      end else if (divCnt == ratioLat) begin
        divCnt  <= '0;
        bclkRaw <= ~bclkRaw;
        if (bclkRaw) begin
          if (bitCnt == lenLat) bitCnt <= '0;
          else                  bitCnt <= bitCnt + CNT_W'(1);
        end
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
    end
  end

  assign bitEdge  = ctl.run && bclkRaw && (divCnt == ratioLat);
  assign fclkRaw  = ctl.run && (bitCnt >= halfLat);
  assign bitStb   = bitEdge;
  assign frameStb = bitEdge && (bitCnt == lenLat);
  assign halfStb  = bitEdge && (bitCnt == halfLat - CNT_W'(1));

  // polarity stage, one variant per output
  generate
    for (genvar g = 0; g < 2; g++) begin : g_pol
      if (g == 0) begin : g_bit
        assign bclkOut = (ctl.run & bclkRaw) ^ bclkInv;
      end else begin : g_frame
        assign fclkOut = fclkRaw ^ fclkInv;
      end
    end
  endgenerate

  // R7: counters cleared after a disabled cycle
  a_r7_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !ctl.run |=> (divCnt == '0 && bitCnt == '0 && !bclkRaw));
  // R2: half-period count stays in range
  a_r2_div_bound: assert property (@(posedge clk) disable iff (rst)
    ctl.run |-> divCnt <= ratioLat);
  // R8: a bit strobe is followed by a low bit clock
  a_r8_fall_next: assert property (@(posedge clk) disable iff (rst)
    bitStb |=> !bclkRaw);
  // R5: the frame clock is low right after a frame strobe
  a_r5_frame_low: assert property (@(posedge clk) disable iff (rst)
    frameStb |=> !fclkRaw);
  // R10: settings frozen while running
  a_r10_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (ctl.run && $past(ctl.run)) |-> ($stable(ratioLat) && $stable(lenLat) && $stable(halfLat)));
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import audio_clk_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startCmd,
  input  logic             pauseCmd,
  input  logic             stopCmd,
  input  logic             contMode,
  input  logic [DIV_W-1:0] ratioM1,
  input  logic [CNT_W-1:0] frameM1,
  input  logic [1:0]       payloadCode,
  input  logic             lenFromCount,
  input  logic             bclkInv,
  input  logic             fclkInv,
  output logic             bclkOut,
  output logic             fclkOut,
  output logic             bitStb,
  output logic             frameStb,
  output logic             halfStb
);
  clkCtl_t ctl;

  audio_clk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startCmd(startCmd), .pauseCmd(pauseCmd),
    .stopCmd(stopCmd), .contMode(contMode), .ctl(ctl)
  );

  audio_clk_dp #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .ratioM1(ratioM1), .frameM1(frameM1),
    .payloadCode(payloadCode), .lenFromCount(lenFromCount),
    .bclkInv(bclkInv), .fclkInv(fclkInv), .bclkOut(bclkOut), .fclkOut(fclkOut),
    .bitStb(bitStb), .frameStb(frameStb), .halfStb(halfStb)
  );
endmodule

// File: tb/audio_clk_gen_tb.sv
module audio_clk_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startCmd = 0, pauseCmd = 0, stopCmd = 0, contMode = 0;
  logic [5:0]  ratioM1 = 0;
  logic [11:0] frameM1 = 0;
  logic [1:0]  payloadCode = 0;
  logic lenFromCount = 0, bclkInv = 0, fclkInv = 0;
  logic bclkOut, fclkOut, bitStb, frameStb, halfStb;

  int nChecks = 0, nFails = 0, cycles = 0;
  string scen = "R1";
  bit modelOn = 0;

  // behavioural model state
  int  mRun = 0, mN = 0, mR = 1, mL = 32;

  always #10 clk = ~clk;

  audio_clk_gen u_dut (
    .clk(clk), .rst(rst), .startCmd(startCmd), .pauseCmd(pauseCmd),
    .stopCmd(stopCmd), .contMode(contMode), .ratioM1(ratioM1), .frameM1(frameM1),
    .payloadCode(payloadCode), .lenFromCount(lenFromCount), .bclkInv(bclkInv),
    .fclkInv(fclkInv), .bclkOut(bclkOut), .fclkOut(fclkOut), .bitStb(bitStb),
    .frameStb(frameStb), .halfStb(halfStb)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, scen, $time, act, exp);
    end
  endtask

  // model update: settings captured while stopped, time counted since start
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      mRun = 0; mN = 0;
    end else begin
      int prev, nxt;
      prev = mRun;
      if (prev == 0) begin
        mR = int'(ratioM1) + 1;
        if (lenFromCount) mL = int'(frameM1) + 1;
        else mL = (payloadCode == 2) ? 48 : (payloadCode == 3) ? 64 : 32;
      end
      if (stopCmd) nxt = 0;
      else if (pauseCmd && !contMode) nxt = 0;
      else if (startCmd) nxt = 1;
      else nxt = prev;
      if (prev == 1 && nxt == 1) mN++;
      else mN = 0;
      mRun = nxt;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (modelOn && !rst) begin
      int eb, ef, es, efr, eh, bitIdx, pos, half;
      if (mRun == 1) begin
        half   = mL / 2;
        bitIdx = mN / (2 * mR);
        pos    = bitIdx % mL;
        eb  = (mN / mR) % 2;
        ef  = (pos >= half) ? 1 : 0;
        es  = ((mN + 1) % (2 * mR) == 0) ? 1 : 0;
        efr = (es == 1 && pos == mL - 1) ? 1 : 0;
        eh  = (es == 1 && pos == half - 1) ? 1 : 0;
        check(bclkOut == ((eb != 0) ^ bclkInv), "R2/R4 bclk", bclkOut, (eb != 0) ^ bclkInv);
        check(fclkOut == ((ef != 0) ^ fclkInv), "R5/R3 fclk", fclkOut, (ef != 0) ^ fclkInv);
        check(bitStb == es[0], "R8 bitStb", bitStb, es);
        check(frameStb == efr[0], "R9 frameStb", frameStb, efr);
        check(halfStb == eh[0], "R9 halfStb", halfStb, eh);
      end else begin
        check(bclkOut == bclkInv, "R7/R4 idle bclk", bclkOut, bclkInv);
        check(fclkOut == fclkInv, "R7/R4 idle fclk", fclkOut, fclkInv);
        check({bitStb, frameStb, halfStb} == 3'b000, "R7 idle strobes",
              {bitStb, frameStb, halfStb}, 0);
      end
    end
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #3;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #3;
    if (which == 0) startCmd = 1;
    if (which == 1) pauseCmd = 1;
    if (which == 2) stopCmd = 1;
    @(posedge clk); #3;
    startCmd = 0; pauseCmd = 0; stopCmd = 0;
  endtask

  // counts bit strobes seen at falling edges over a window
  task automatic countStb(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bitStb) cnt++;
    end
    #3;
  endtask

  initial begin
    int cnt;
    // R1: reset state
    waitCyc(3);
    rst = 0;
    @(negedge clk);
    check(bclkOut == 1'b0 && fclkOut == 1'b0, "R1 reset clocks", {bclkOut, fclkOut}, 0);
    check({bitStb, frameStb, halfStb} == 3'b000, "R1 reset strobes", {bitStb, frameStb, halfStb}, 0);
    bclkInv = 1; fclkInv = 1; #1;
    check(bclkOut == 1'b1 && fclkOut == 1'b1, "R1 reset inverted", {bclkOut, fclkOut}, 3);
    bclkInv = 0; fclkInv = 0;
    modelOn = 1;

    // R2/R3: fastest ratio, count field of 8
    scen = "R2 ratio1 len8";
    ratioM1 = 0; lenFromCount = 1; frameM1 = 7;
    pulse(0); waitCyc(100);
    pulse(2); waitCyc(5);

    // R3: code 0, ratio 3, inverted bit clock
    scen = "R3 code0";
    ratioM1 = 2; lenFromCount = 0; payloadCode = 0; bclkInv = 1;
    pulse(0); waitCyc(300);
    // R10: changes while running ignored
    scen = "R10 frozen";
    ratioM1 = 9; payloadCode = 3;
    countStb(60, cnt);
    check(cnt == 10, "R10 ratio unchanged", cnt, 10);
    waitCyc(200);
    pulse(2); waitCyc(4);

    // R3: code 2 with inverted frame clock
    scen = "R3 code2";
    ratioM1 = 0; payloadCode = 2; bclkInv = 0; fclkInv = 1;
    pulse(0); waitCyc(250);
    // R6: continuous pause keeps running
    scen = "R6 cont pause";
    contMode = 1; pulse(1);
    countStb(20, cnt);
    check(cnt == 10, "R6 cont pause running", cnt, 10);
    // R6: gated pause stops
    scen = "R6 gated pause";
    contMode = 0; pulse(1);
    countStb(20, cnt);
    check(cnt == 0, "R6 gated pause stopped", cnt, 0);

    // R3: code 3, both inverted, restart from zero (R7)
    scen = "R7 restart code3";
    ratioM1 = 1; payloadCode = 3; bclkInv = 1; fclkInv = 1;
    pulse(0); waitCyc(600);
    pulse(2); waitCyc(4);

    // R3: unused code 1 falls back to 32
    scen = "R3 code1";
    ratioM1 = 0; payloadCode = 1; bclkInv = 0; fclkInv = 0;
    pulse(0); waitCyc(150);
    pulse(2); waitCyc(4);

    // R5/R9: odd frame length
    scen = "R5 odd len5";
    lenFromCount = 1; frameM1 = 4; ratioM1 = 1;
    pulse(0); waitCyc(120);

    // R6: stop beats start in the same cycle
    scen = "R6 stop priority";
    @(posedge clk); #3; startCmd = 1; stopCmd = 1;
    @(posedge clk); #3; startCmd = 0; stopCmd = 0;
    countStb(20, cnt);
    check(cnt == 0, "R6 stop over start", cnt, 0);
    // R6: gated pause beats start
    @(posedge clk); #3; startCmd = 1; pauseCmd = 1;
    @(posedge clk); #3; startCmd = 0; pauseCmd = 0;
    countStb(20, cnt);
    check(cnt == 0, "R6 pause over start", cnt, 0);
    // R6: stop with continuous mode still stops
    contMode = 1; pulse(0); waitCyc(30);
    pulse(2);
    countStb(20, cnt);
    check(cnt == 0, "R6 stop in cont mode", cnt, 0);

    modelOn = 0;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule